// File: doc/BRIEF.md
# Sticky Event Flags with Masked Interrupt Request

This block is the status and interrupt-request stage of a timer-style peripheral. Each event input, such as a counter overflow or a transfer-complete pulse, sets a sticky flag of its own. The flag is recorded whether or not its interrupt is enabled. A separate enable mask picks which flags may drive the single level-type request line that goes to the interrupt controller.

Software reaches the block through a simple single-cycle register port. The port carries valid, write, address and data, and its read data is combinational. The status register sits at offset 0. Writing it clears every flag whose data bit is zero and leaves every flag whose data bit is one, so a write of the inverted bit mask clears exactly one flag. The enable register sits at offset 1. Because flags keep recording while their sources are masked, enabling a source whose flag is already set raises the request at once. To avoid that, software clears the flag before it sets the enable bit.

Top module: `intr_flag_unit`

## Requirements
- R1: Under reset (`rstN` low), every flag and every enable bit is zero and `irqOut` is low.
- R2: An event bit that is high at a clock edge sets its flag at that edge, whatever the value of its enable bit.
- R3: A write to offset 0 clears each flag whose data bit is 0. Each flag whose data bit is 1 keeps its value.
- R4: When an event and a clearing write to offset 0 reach the same flag at the same edge, the flag ends up set.
- R5: `irqOut` is high exactly when at least one source has both its flag and its enable bit set.
- R6: A write to offset 1 that sets the enable bit of a flag that is already set raises `irqOut` in the cycle right after that edge, with no new event.
- R7: A write to offset 1 that clears an enable bit removes that source from `irqOut` and leaves its flag unchanged.
- R8: A write to offset 1 stores the data as the enable mask. A read of offset 1 returns that mask, and a read of offset 0 returns the flags, bit i for source i.
- R9: Accesses change no state when `regValid` is low, when `regWrite` is low, or when the address is neither 0 nor 1. Reads of any other address return zero.
- R10: While an enabled flag stays set, `irqOut` stays high across cycles that bring no new event and no register write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| evtIn | input | NUM_SRC | Event inputs, one per source, sampled at each edge |
| regValid | input | 1 | Register access valid |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | ADDR_W | Register offset: 0 is status, 1 is enable |
| regWdata | input | NUM_SRC | Write data |
| regRdata | output | NUM_SRC | Read data, combinational from the current state |
| irqOut | output | 1 | Level-type interrupt request |

## Verification
Every flag and enable change takes effect at the edge that samples the event or the write. Because `irqOut` and the read data come straight from those registers, each result shows up within one cycle. The bench drives inputs at the falling edge and removes them just after the rising edge. It then reads both registers back through the port and samples `irqOut` in that same cycle, before the next falling edge. Reads never change state, so the read-back cannot disturb the next vector. The reset checks sample a few time units after `rstN` falls, with no clock edge between.

// File: rtl/intr_flag_pkg.sv
package intr_flag_pkg;

  localparam int unsigned STATUS_OFS = 0;
  localparam int unsigned ENABLE_OFS = 1;

  typedef struct packed {
    logic statusWr;
    logic enableWr;
    logic rdStatus;
    logic rdEnable;
  } ctlStrobes_t;

endpackage

// File: rtl/intr_flag_ctl.sv
module intr_flag_ctl
  import intr_flag_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  output ctlStrobes_t       strobes
);

  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(STATUS_OFS);
  localparam logic [ADDR_W-1:0] ENABLE_ADDR = ADDR_W'(ENABLE_OFS);

  logic hitStatus;
  logic hitEnable;

  always_comb begin
    hitStatus        = regValid && (regAddr == STATUS_ADDR);
    hitEnable        = regValid && (regAddr == ENABLE_ADDR);
    strobes.statusWr = hitStatus && regWrite;
    strobes.enableWr = hitEnable && regWrite;
    strobes.rdStatus = hitStatus && !regWrite;
    strobes.rdEnable = hitEnable && !regWrite;
  end

endmodule

// File: rtl/intr_flag_dp.sv
module intr_flag_dp
  import intr_flag_pkg::*;
#(
  parameter int unsigned NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtIn,
  input  logic [NUM_SRC-1:0] regWdata,
  input  ctlStrobes_t        strobes,
  output logic [NUM_SRC-1:0] flagsQ,
  output logic [NUM_SRC-1:0] enQ,
  output logic [NUM_SRC-1:0] regRdata,
  output logic               irqOut
);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    // event beats clear: set has priority over the write-zero clear
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flagsQ[g] <= 1'b0;
      end else if (evtIn[g]) begin
        flagsQ[g] <= 1'b1;
      end else if (strobes.statusWr && !regWdata[g]) begin
        flagsQ[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enQ[g] <= 1'b0;
      end else if (strobes.enableWr) begin
        enQ[g] <= regWdata[g];
      end
    end
  end

  always_comb begin
    regRdata = '0;
    if (strobes.rdStatus) regRdata = flagsQ;
    if (strobes.rdEnable) regRdata = enQ;
  end

  assign irqOut = |(flagsQ & enQ);

endmodule

// File: rtl/intr_flag_unit.sv
module intr_flag_unit
  import intr_flag_pkg::*;
#(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned ADDR_W  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtIn,
  input  logic               regValid,
  input  logic               regWrite,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [NUM_SRC-1:0] regWdata,
  output logic [NUM_SRC-1:0] regRdata,
  output logic               irqOut
);

  ctlStrobes_t        strobes;
  logic [NUM_SRC-1:0] flagsQ;
  logic [NUM_SRC-1:0] enQ;

  intr_flag_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .regValid (regValid),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .strobes  (strobes)
  );

  intr_flag_dp #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .evtIn    (evtIn),
    .regWdata (regWdata),
    .strobes  (strobes),
    .flagsQ   (flagsQ),
    .enQ      (enQ),
    .regRdata (regRdata),
    .irqOut   (irqOut)
  );

endmodule

// File: rtl/intr_flag_unit_chk.sv
module intr_flag_unit_chk #(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned ADDR_W  = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] evtIn,
  input logic               regValid,
  input logic               regWrite,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [NUM_SRC-1:0] regWdata,
  input logic [NUM_SRC-1:0] flagsQ,
  input logic [NUM_SRC-1:0] enQ,
  input logic               irqOut
);

  logic statusWr;
  logic enableWr;
  assign statusWr = regValid && regWrite && (regAddr == ADDR_W'(0));
  assign enableWr = regValid && regWrite && (regAddr == ADDR_W'(1));

  // R2 and R4: an event always leaves its flag set
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn != '0) |=> ((flagsQ & $past(evtIn)) == $past(evtIn)));

  // R3: zero data bits without an event leave the flag cleared
  a_r3_zero_clears: assert property (@(posedge clk) disable iff (!rstN)
    statusWr |=> ((flagsQ & ~$past(regWdata) & ~$past(evtIn)) == '0));

  // R6: enabling an already-set flag raises the request next cycle
  a_r6_enable_raises: assert property (@(posedge clk) disable iff (!rstN)
    (enableWr && !statusWr && ((regWdata & flagsQ) != '0)) |=> irqOut);

  // R7: an enable write alone never changes the flags
  a_r7_flags_kept: assert property (@(posedge clk) disable iff (!rstN)
    (enableWr && (evtIn == '0)) |=> $stable(flagsQ));

  // R9: with no access and no event, the state holds
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!regValid && (evtIn == '0)) |=> ($stable(flagsQ) && $stable(enQ)));

  // R10: the level request persists without a register write
  a_r10_level_holds: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !(regValid && regWrite)) |=> irqOut);

endmodule

bind intr_flag_unit intr_flag_unit_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_intr_flag_unit.sv
module test_intr_flag_unit;

  localparam int unsigned NS = 4;
  localparam int unsigned AW = 2;

  typedef struct packed {
    logic [NS-1:0] evt;
    logic          v;
    logic          w;
    logic [AW-1:0] a;
    logic [NS-1:0] d;
    logic [NS-1:0] expF;
    logic [NS-1:0] expE;
    logic          expI;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{4'b0001, 1'b0, 1'b0, 2'd0, 4'h0, 4'h1, 4'h0, 1'b0}, // R2 masked event still sets
    '{4'b0100, 1'b0, 1'b0, 2'd0, 4'h0, 4'h5, 4'h0, 1'b0}, // R2
    '{4'b0000, 1'b1, 1'b1, 2'd1, 4'h1, 4'h5, 4'h1, 1'b1}, // R6 enable on set flag
    '{4'b0000, 1'b0, 1'b0, 2'd0, 4'h0, 4'h5, 4'h1, 1'b1}, // R10 level holds
    '{4'b0000, 1'b1, 1'b1, 2'd0, 4'hE, 4'h4, 4'h1, 1'b0}, // R3 inverted mask clears bit0
    '{4'b0000, 1'b1, 1'b1, 2'd1, 4'hF, 4'h4, 4'hF, 1'b1}, // R6 R8
    '{4'b0000, 1'b1, 1'b1, 2'd1, 4'hB, 4'h4, 4'hB, 1'b0}, // R7 mask off, flag kept
    '{4'b0010, 1'b0, 1'b0, 2'd0, 4'h0, 4'h6, 4'hB, 1'b1}, // R5
    '{4'b0010, 1'b1, 1'b1, 2'd0, 4'hD, 4'h6, 4'hB, 1'b1}, // R4 event beats clear
    '{4'b0000, 1'b1, 1'b1, 2'd0, 4'hF, 4'h6, 4'hB, 1'b1}, // R3 ones keep flags
    '{4'b0000, 1'b1, 1'b1, 2'd2, 4'h0, 4'h6, 4'hB, 1'b1}, // R9 unmapped write
    '{4'b0000, 1'b0, 1'b1, 2'd0, 4'h0, 4'h6, 4'hB, 1'b1}, // R9 valid low
    '{4'b0000, 1'b1, 1'b0, 2'd0, 4'h0, 4'h6, 4'hB, 1'b1}, // R9 read only
    '{4'b0000, 1'b1, 1'b1, 2'd1, 4'h9, 4'h6, 4'h9, 1'b0}, // R5 R8 no overlap
    '{4'b0000, 1'b1, 1'b1, 2'd0, 4'h0, 4'h0, 4'h9, 1'b0}, // R3 clear all
    '{4'b1000, 1'b0, 1'b0, 2'd0, 4'h0, 4'h8, 4'h9, 1'b1}  // R2 R5
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] evtIn = '0;
  logic          regValid = 1'b0;
  logic          regWrite = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [NS-1:0] regWdata = '0;
  logic [NS-1:0] regRdata;
  logic          irqOut;

  int errCnt = 0;
  int chkCnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  intr_flag_unit #(.NUM_SRC(NS), .ADDR_W(AW)) i_intr_flag_unit (.*);

  task automatic check(input string req, input int act, input int exp);
    chkCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // read both registers through the port, no clock edge in between
  task automatic readBack(output logic [NS-1:0] f, output logic [NS-1:0] e);
    regValid = 1'b1; regWrite = 1'b0; regAddr = 2'd0;
    #1 f = regRdata;
    regAddr = 2'd1;
    #1 e = regRdata;
    regValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      chkCnt++;
      errCnt++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    logic [NS-1:0] f, e;
    repeat (3) @(negedge clk);
    // R1: reset state
    readBack(f, e);
    check("R1 flags", f, 0);
    check("R1 enable", e, 0);
    check("R1 irq", irqOut, 0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      evtIn = VECS[i].evt; regValid = VECS[i].v; regWrite = VECS[i].w;
      regAddr = VECS[i].a; regWdata = VECS[i].d;
      @(posedge clk);
      #1;
      evtIn = '0; regValid = 1'b0; regWrite = 1'b0; regWdata = '0;
      readBack(f, e);
      check($sformatf("vec%0d flags", i), f, VECS[i].expF);
      check($sformatf("vec%0d enable", i), e, VECS[i].expE);
      check($sformatf("vec%0d irq", i), irqOut, VECS[i].expI);
    end

    // R9: unmapped read returns zero
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regAddr = 2'd3;
    #1 check("R9 unmapped read", regRdata, 0);
    regValid = 1'b0;

    // R1: reset in the middle of a run clears everything at once
    @(negedge clk);
    rstN = 1'b0;
    #2;
    readBack(f, e);
    check("R1 mid flags", f, 0);
    check("R1 mid enable", e, 0);
    check("R1 mid irq", irqOut, 0);
    @(negedge clk);
    rstN = 1'b1;

    done = 1'b1;
    finishRun();
  end

endmodule